// File: doc/BRIEF.md
# Auto-Negotiation Priority Resolver

This block settles the operating mode of a 10/100 Ethernet link once auto-negotiation has finished. It receives the local advertisement word and the link partner ability word, both 16 bits wide. It intersects the technology abilities the two ends share and picks the single best common mode under a fixed five-level ranking. In that ranking, the four-pair 100 Mb/s half-duplex mode sits between 100 Mb/s full duplex and two-pair 100 Mb/s half duplex.

The resolution is combinational. An external completion strobe captures the result into registers, and the result is held there until the next strobe. The chosen mode appears on three outputs: a one-hot vector, a small numeric code, and separate speed and duplex bits. A flag marks the case in which no usable common mode exists. Pulse signalling, the negotiation state machine and next-page exchange belong to other blocks.

Top module: `an_resolver`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe seen yet, all outputs are zero: `mode_onehot`=0, `mode_code`=0, `speed_100`=0, `full_duplex`=0, `no_common`=0.
- R2: When `an_done` is high at a rising clock edge, the result of the words present at that edge is visible on the outputs right after that edge.
- R3: While `an_done` is low, every output keeps its value, whatever the two ability words do.
- R4: The common set is the AND of bits 9:5 of the two words. The ability bits are: 5 = 10 Mb/s half, 6 = 10 Mb/s full, 7 = 100 Mb/s two-pair half, 8 = 100 Mb/s two-pair full, 9 = 100 Mb/s four-pair. The winner is the highest-ranked member of the common set, ranked from best down: bit 8, bit 9, bit 7, bit 6, bit 5.
- R5: If the partner selector (bits 4:0) is not 00001, the strobe stores `no_common`=1 and `mode_onehot`=0.
- R6: If the common set is empty, the strobe stores `no_common`=1 and `mode_onehot`=0.
- R7: If the local selector (bits 4:0) is not 00001, the strobe stores `no_common`=1 and `mode_onehot`=0.
- R8: Bit i of `mode_onehot` marks the mode of ability bit 5+i. `mode_code` takes these values: 5 = bit 8, 4 = bit 9, 3 = bit 7, 2 = bit 6, 1 = bit 5, 0 = none. `speed_100` is 1 for bits 7, 8 and 9. `full_duplex` is 1 for bits 6 and 8. At most one bit of `mode_onehot` is set.
- R9: Bits 15:10 of both words, including the next-page bit, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| an_done | input | 1 | Negotiation-complete strobe; captures the resolution |
| local_adv | input | 16 | Local advertisement word |
| partner_abl | input | 16 | Link partner ability word |
| mode_onehot | output | 5 | Selected mode, one-hot, bit i = ability bit 5+i |
| mode_code | output | 3 | Selected mode as a rank code, 0 = none |
| speed_100 | output | 1 | Selected mode runs at 100 Mb/s |
| full_duplex | output | 1 | Selected mode is full duplex |
| no_common | output | 1 | No usable common mode at the last strobe |

## Verification
A faulty priority chain or a wrong common-set mask shows up on the cycle right after the strobe. In that case `mode_onehot` names a lower-ranked mode or a mode that one of the ends lacks. A broken capture enable shows up as outputs that drift between strobes, so the bench also compares those cycles. A wrong encoder mapping only shows up in the code, speed or duplex bits, while `mode_onehot` stays correct. For that reason all five outputs are compared on every clock.

// File: rtl/an_res_pkg.sv
package an_res_pkg;

  localparam int WORD_W   = 16;
  localparam int SEL_W    = 5;
  localparam int TECH_LO  = 5;
  localparam int TECH_N   = 5;
  localparam int CODE_W   = $clog2(TECH_N + 1);
  localparam logic [SEL_W-1:0] SEL_8023 = 5'b00001;

  // Slot s is ability bit TECH_LO+s:
  // slot 0 = 10 half, 1 = 10 full, 2 = 100 two-pair half, 3 = 100 two-pair full, 4 = 100 four-pair.

  // Slot occupying rank r (rank 0 = best).
  function automatic int slot_at_rank(input int r);
    case (r)
      0:       return 3;
      1:       return 4;
      2:       return 2;
      3:       return 1;
      default: return 0;
    endcase
  endfunction

  // Numeric code of a slot (higher = better, 0 reserved for none).
  function automatic int code_of_slot(input int s);
    for (int r = 0; r < TECH_N; r++) begin
      if (slot_at_rank(r) == s) return TECH_N - r;
    end
    return 0;
  endfunction

  function automatic logic slot_is_100(input int s);
    return (s >= 2);
  endfunction

  function automatic logic slot_is_full(input int s);
    return (s == 1) || (s == 3);
  endfunction

endpackage

// File: rtl/an_common_set.sv
module an_common_set
  import an_res_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int SW    = SEL_W,
  parameter int LO    = TECH_LO,
  parameter int N     = TECH_N
) (
  input  logic [W-1:0] local_word,
  input  logic [W-1:0] partner_word,
  output logic [N-1:0] shared,
  output logic         sel_ok
);
  localparam int HI = LO + N - 1;

  logic local_sel_ok;
  logic partner_sel_ok;

  assign local_sel_ok   = (local_word[SW-1:0]   == SEL_8023);
  assign partner_sel_ok = (partner_word[SW-1:0] == SEL_8023);
  assign sel_ok         = local_sel_ok & partner_sel_ok;

  for (genvar s = 0; s < N; s++) begin : g_and
    assign shared[s] = local_word[LO+s] & partner_word[LO+s];
  end

  logic unused_hi;
  assign unused_hi = ^{local_word[W-1:HI+1], partner_word[W-1:HI+1]};

endmodule

// File: rtl/an_prio_pick.sv
module an_prio_pick
  import an_res_pkg::*;
#(
  parameter int N = TECH_N
) (
  input  logic [N-1:0] shared,
  input  logic         enable,
  output logic [N-1:0] pick,
  output logic         none
);
  logic [N:0]   taken;
  logic [N-1:0] win_by_rank;

  assign taken[0] = 1'b0;

  for (genvar r = 0; r < N; r++) begin : g_rank
    localparam int SLOT = slot_at_rank(r);
    logic hit;
    assign hit            = enable & shared[SLOT];
    assign win_by_rank[r] = hit & ~taken[r];
    assign taken[r+1]     = taken[r] | hit;
    assign pick[SLOT]     = win_by_rank[r];
  end

  assign none = ~taken[N];

endmodule

// File: rtl/an_mode_encode.sv
module an_mode_encode
  import an_res_pkg::*;
#(
  parameter int N  = TECH_N,
  parameter int CW = CODE_W
) (
  input  logic [N-1:0]  onehot,
  output logic [CW-1:0] code,
  output logic          is_100,
  output logic          is_full
);
  always_comb begin
    code    = '0;
    is_100  = 1'b0;
    is_full = 1'b0;
    for (int s = 0; s < N; s++) begin
      if (onehot[s]) begin
        code    = CW'(code_of_slot(s));
        is_100  = slot_is_100(s);
        is_full = slot_is_full(s);
      end
    end
  end
endmodule

// File: rtl/an_resolver.sv
module an_resolver
  import an_res_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int N  = TECH_N,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          an_done,
  input  logic [W-1:0]  local_adv,
  input  logic [W-1:0]  partner_abl,
  output logic [N-1:0]  mode_onehot,
  output logic [CW-1:0] mode_code,
  output logic          speed_100,
  output logic          full_duplex,
  output logic          no_common
);
  logic [N-1:0] shared_set;
  logic         sel_ok;
  logic [N-1:0] pick_now;
  logic         none_now;

  an_common_set #(.W(W), .N(N)) u_set (
    .local_word  (local_adv),
    .partner_word(partner_abl),
    .shared      (shared_set),
    .sel_ok      (sel_ok)
  );

  an_prio_pick #(.N(N)) u_pick (
    .shared(shared_set),
    .enable(sel_ok),
    .pick  (pick_now),
    .none  (none_now)
  );

  logic [N-1:0] onehot_q;
  logic         none_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onehot_q <= '0;
      none_q   <= 1'b0;
    end else if (an_done) begin
      onehot_q <= pick_now;
      none_q   <= none_now;
    end
  end

  an_mode_encode #(.N(N), .CW(CW)) u_enc (
    .onehot (onehot_q),
    .code   (mode_code),
    .is_100 (speed_100),
    .is_full(full_duplex)
  );

  assign mode_onehot = onehot_q;
  assign no_common   = none_q;

endmodule

// File: rtl/an_resolver_chk.sv
module an_resolver_chk
  import an_res_pkg::*;
#(
  parameter int N  = TECH_N,
  parameter int CW = CODE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          an_done,
  input logic [SEL_W-1:0] partner_sel,
  input logic [SEL_W-1:0] local_sel,
  input logic [N-1:0]  shared_set,
  input logic [N-1:0]  mode_onehot,
  input logic [CW-1:0] mode_code,
  input logic          speed_100,
  input logic          full_duplex,
  input logic          no_common
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !an_done |=> ($stable(mode_onehot) && $stable(no_common) && $stable(mode_code)));

  assert_best_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && partner_sel == SEL_8023 && local_sel == SEL_8023 && shared_set[3])
      |=> mode_onehot[3]);

  assert_badsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && partner_sel != SEL_8023) |=> (no_common && mode_onehot == '0));

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && shared_set == '0) |=> (no_common && mode_onehot == '0));

  assert_localsel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && local_sel != SEL_8023) |=> no_common);

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_onehot));

  assert_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_code == '0) == (mode_onehot == '0)) && (!speed_100 || mode_onehot[4:2] != '0)
      && (!full_duplex || mode_onehot[1] || mode_onehot[3]));

  assert_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    an_done |=> (no_common == (mode_onehot == '0)));
endmodule

bind an_resolver an_resolver_chk #(.N(N), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .an_done    (an_done),
  .partner_sel(partner_abl[4:0]),
  .local_sel  (local_adv[4:0]),
  .shared_set (shared_set),
  .mode_onehot(mode_onehot),
  .mode_code  (mode_code),
  .speed_100  (speed_100),
  .full_duplex(full_duplex),
  .no_common  (no_common)
);

// File: tb/an_resolver_tb.sv
module an_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        an_done = 1'b0;
  logic [15:0] local_adv = '0;
  logic [15:0] partner_abl = '0;
  logic [4:0]  mode_onehot;
  logic [2:0]  mode_code;
  logic        speed_100, full_duplex, no_common;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // expected state
  logic [4:0] e_oh = '0;
  int         e_code = 0;
  bit         e_spd = 0, e_fd = 0, e_nc = 0;

  always #2 clk = ~clk;

  an_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .an_done(an_done),
    .local_adv(local_adv), .partner_abl(partner_abl),
    .mode_onehot(mode_onehot), .mode_code(mode_code),
    .speed_100(speed_100), .full_duplex(full_duplex), .no_common(no_common)
  );

  // Reference: walk the ranking list of ability bits, best first.
  task automatic model(input logic [15:0] la, input logic [15:0] pa);
    int order[5] = '{8, 9, 7, 6, 5};
    e_oh = '0; e_code = 0; e_spd = 0; e_fd = 0; e_nc = 1;
    if (la[4:0] != 5'd1 || pa[4:0] != 5'd1) return;
    foreach (order[k]) begin
      int b = order[k];
      if (la[b] && pa[b]) begin
        e_oh[b-5] = 1'b1;
        e_code = 5 - k;
        e_spd = (b >= 7);
        e_fd = (b == 8 || b == 6);
        e_nc = 0;
        return;
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (mode_onehot !== e_oh || mode_code !== 3'(e_code) || speed_100 !== e_spd ||
        full_duplex !== e_fd || no_common !== e_nc) begin
      errors++;
      $display("FAIL %s: got oh=%b code=%0d spd=%b fd=%b nc=%b exp oh=%b code=%0d spd=%b fd=%b nc=%b",
               tag, mode_onehot, mode_code, speed_100, full_duplex, no_common,
               e_oh, e_code, e_spd, e_fd, e_nc);
    end
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic cycle(input bit d, input logic [15:0] la, input logic [15:0] pa, input string tag);
    an_done = d; local_adv = la; partner_abl = pa;
    @(posedge clk);
    if (d) model(la, pa);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [15:0] w(input logic [4:0] tech, input logic [4:0] sel);
    return {6'b0, tech, sel};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");
    cycle(0, w(5'h1f, 1), w(5'h1f, 1), "R1 no strobe");

    // R4 ranking walk, R2 capture, R8 encodings
    cycle(1, w(5'b11111, 1), w(5'b11111, 1), "R4 all -> 100 full");
    cycle(1, w(5'b10111, 1), w(5'b11111, 1), "R4 four-pair");
    cycle(1, w(5'b00111, 1), w(5'b11111, 1), "R4 100 half");
    cycle(1, w(5'b00011, 1), w(5'b11111, 1), "R8 10 full");
    cycle(1, w(5'b00001, 1), w(5'b11111, 1), "R8 10 half");
    cycle(1, w(5'b11000, 1), w(5'b10100, 1), "R4 only four-pair shared");
    cycle(1, w(5'b01110, 1), w(5'b10101, 1), "R4 only 100 half shared");
    cycle(1, w(5'b11111, 1), w(5'b01000, 1), "R2 partner only 100 full");
    // R6 empty
    cycle(1, w(5'b01010, 1), w(5'b10101, 1), "R6 empty common set");
    cycle(1, w(5'b11111, 1), w(5'b11111, 1), "R2 recover");
    // R5 bad partner selector
    cycle(1, w(5'b11111, 1), w(5'b11111, 5'b00010), "R5 partner selector");
    cycle(1, w(5'b11111, 1), w(5'b11111, 5'b00000), "R5 partner selector zero");
    // R7 bad local selector
    cycle(1, w(5'b11111, 5'b10001), w(5'b11111, 1), "R7 local selector");
    // R3 hold
    cycle(1, w(5'b00100, 1), w(5'b00100, 1), "R3 load 100 half");
    cycle(0, w(5'b11111, 1), w(5'b11111, 1), "R3 hold vs better");
    cycle(0, w(5'b00000, 1), w(5'b11111, 1), "R3 hold vs empty");
    cycle(0, w(5'b11111, 3), w(5'b11111, 7), "R3 hold vs bad selectors");
    // R9 upper bits ignored
    cycle(1, {6'h3f, 5'b00011, 5'd1}, {6'h2a, 5'b00011, 5'd1}, "R9 upper bits set");
    cycle(1, {6'h20, 5'b00000, 5'd1}, {6'h3f, 5'b11111, 5'd1}, "R9 next-page bit");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] la, pa;
      la = 16'($urandom);
      pa = 16'($urandom);
      if ($urandom_range(0, 7) != 0) la[4:0] = 5'd1;
      if ($urandom_range(0, 7) != 0) pa[4:0] = 5'd1;
      cycle(bit'($urandom_range(0, 1)), la, pa, "R4 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule